// File: doc/BRIEF.md
# Banked Interrupt Priority Array

This block holds one eight-bit priority value for each of 32 private interrupts of a single processor. Software reaches the array through a simple request port: a byte access touches one priority, and an aligned 32-bit word access touches four consecutive priorities at once. The priorities are also presented as a flat vector, so a neighbouring arbiter can compare them without using the request port.

Each access carries a secure attribute. The block also takes a security-disable input and a group bitmap that classifies every interrupt as group 0 or group 1. When security is disabled, or when the access is secure, the array behaves as plain storage. A non-secure access made while security is enabled gets a restricted view. Group-0 entries read as zero and cannot be written. Group-1 entries are seen at half range: they read back shifted left by one, and a write lands in the upper half of the priority scale. A word access applies this translation to each byte separately.

Top module: `prio_bank_ram`

## Requirements
- R1: After reset every stored priority is 0x00, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: When `secure_i`=1 or `sec_dis_i`=1, a write stores the supplied byte unchanged, and a read returns the stored byte unchanged.
- R3: When `secure_i`=0 and `sec_dis_i`=0, reading an interrupt whose `group_i` bit is 0 (group 0) returns 0x00.
- R4: When `secure_i`=0 and `sec_dis_i`=0, a write to an interrupt whose `group_i` bit is 0 leaves its stored priority unchanged.
- R5: When `secure_i`=0 and `sec_dis_i`=0, reading an interrupt whose `group_i` bit is 1 returns (stored << 1) truncated to 8 bits.
- R6: When `secure_i`=0 and `sec_dis_i`=0, writing value v to an interrupt whose `group_i` bit is 1 stores 0x80 | (v >> 1).
- R7: A word access (`word_i`=1) at byte offset n, with n a multiple of 4, covers interrupts n..n+3, and interrupt n+k uses bits [8k+7:8k] of `wdata_i`/`rdata_o`. A byte access (`word_i`=0) at offset n uses `wdata_i[7:0]`, returns its value in `rdata_o[7:0]`, and returns 0 in `rdata_o[31:8]`.
- R8: Within one word access, the group filtering and translation of R3 to R6 are applied to each of the four bytes independently, according to that byte's own `group_i` bit.
- R9: An access at a byte offset of 32 or more, or a word access whose offset is not a multiple of 4, is an error. An erroneous read returns 0, an erroneous write changes nothing, and no error indication is given.
- R10: Read data appears in `rdata_o` with `rvalid_o`=1 in the cycle after the request, and `rvalid_o` is 0 after a write or an idle cycle. A write is visible on `prio_o` (entry i in bits [8i+7:8i]) in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 32-bit word access, 0 = byte access |
| addr_i | input | 8 | Byte offset into the priority window |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Secure attribute of the access |
| sec_dis_i | input | 1 | Security disabled: every access is treated as secure |
| group_i | input | 32 | Group bitmap, bit i = 1 means interrupt i is group 1 |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| prio_o | output | 256 | Stored priorities, entry i in bits [8i+7:8i] |

## Verification
The embedded assertions check several properties on every cycle. A restricted write never changes a group-0 entry. Any priority changed by a restricted write has its top bit set. Every restricted read returns a zero least significant bit in each byte. Out-of-window reads and the upper bytes of byte reads come back as zero, and the read-valid flag follows read requests exactly. The bench's scenarios are needed to show the exact values. These include the shift arithmetic, the mapping of word lanes to interrupts, mixed groups inside one word, misaligned words, and the pass-through behaviour when security is disabled or the access is secure.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/prio_addr_dec.sv
module prio_addr_dec
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int IDX_W   = 5
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          word_i,
  output logic                          hit_o,
  output logic [LANES-1:0]              lane_en_o,
  output logic [LANES-1:0][IDX_W-1:0]   lane_idx_o
);
  localparam int LSB_W = $clog2(LANES);

  logic in_win, aligned;

  assign in_win  = addr_i < ADDR_W'(NUM_IRQ);
  assign aligned = addr_i[LSB_W-1:0] == '0;
  assign hit_o   = in_win && (!word_i || aligned);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // byte accesses always use lane 0
    assign lane_idx_o[k] = addr_i[IDX_W-1:0] + IDX_W'(k);
    assign lane_en_o[k]  = hit_o && (word_i || (k == 0));
  end
endmodule

// File: rtl/prio_lane_xlate.sv
module prio_lane_xlate
  import prio_bank_pkg::*;
(
  input  logic  restrict_i,
  input  logic  grp1_i,
  input  prio_t stored_i,
  input  prio_t wdata_i,
  output prio_t rdata_o,
  output logic  wr_ok_o,
  output prio_t wval_o
);
  always_comb begin
    if (!restrict_i)  rdata_o = stored_i;
    else if (grp1_i)  rdata_o = {stored_i[PRIO_W-2:0], 1'b0};
    else              rdata_o = '0;
  end

  assign wr_ok_o = !restrict_i || grp1_i;
  assign wval_o  = restrict_i ? {1'b1, wdata_i[PRIO_W-1:1]} : wdata_i;
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int LANES   = 4,
  parameter int IDX_W   = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             wr_en_i,
  input  logic [LANES-1:0][IDX_W-1:0]  idx_i,
  input  prio_t [LANES-1:0]            wdata_i,
  output prio_t [LANES-1:0]            rd_o,
  output logic [NUM_IRQ*PRIO_W-1:0]    flat_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
    prio_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (wr_en_i[k] && idx_i[k] == IDX_W'(i)) ent_q <= wdata_i[k];
        end
      end
    end
    assign flat_o[i*PRIO_W +: PRIO_W] = ent_q;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_o[k] = flat_o[idx_i[k]*PRIO_W +: PRIO_W];
  end
endmodule

// File: rtl/prio_bank_ram.sv
module prio_bank_ram
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic                       word_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       secure_i,
  input  logic                       sec_dis_i,
  input  logic [NUM_IRQ-1:0]         group_i,
  output logic                       rvalid_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_IRQ*PRIO_W-1:0]  prio_o
);
  localparam int LANES = DATA_W / PRIO_W;
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic                        hit, restrict_acc, rd_req;
  logic [LANES-1:0]            lane_en, wr_ok, wr_en;
  logic [LANES-1:0][IDX_W-1:0] lane_idx;
  prio_t [LANES-1:0]           raw_rd, xl_rd, wval;
  logic [DATA_W-1:0]           rd_word;
  logic                        rvalid_q;
  logic [DATA_W-1:0]           rdata_q;

  assign restrict_acc = !secure_i && !sec_dis_i;
  assign rd_req       = req_i && !we_i;

  prio_addr_dec #(
    .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .LANES(LANES), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i    (addr_i),
    .word_i    (word_i),
    .hit_o     (hit),
    .lane_en_o (lane_en),
    .lane_idx_o(lane_idx)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_xl
    prio_lane_xlate u_xl (
      .restrict_i(restrict_acc),
      .grp1_i    (group_i[lane_idx[k]]),
      .stored_i  (raw_rd[k]),
      .wdata_i   (wdata_i[k*PRIO_W +: PRIO_W]),
      .rdata_o   (xl_rd[k]),
      .wr_ok_o   (wr_ok[k]),
      .wval_o    (wval[k])
    );
    assign wr_en[k] = req_i && we_i && lane_en[k] && wr_ok[k];
    assign rd_word[k*PRIO_W +: PRIO_W] = lane_en[k] ? xl_rd[k] : '0;
  end

  prio_store #(
    .NUM_IRQ(NUM_IRQ), .LANES(LANES), .IDX_W(IDX_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .idx_i  (lane_idx),
    .wdata_i(wval),
    .rd_o   (raw_rd),
    .flat_o (prio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_word : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  // ---------------- assertions ----------------
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    p_grp0_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && restrict_acc && !group_i[i])
        |=> $stable(prio_o[i*PRIO_W +: PRIO_W]));

    p_ns_wr_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && restrict_acc)
        |=> ($stable(prio_o[i*PRIO_W +: PRIO_W]) || prio_o[i*PRIO_W + PRIO_W - 1]));
  end

  p_rvalid_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  p_rvalid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);

  p_err_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i >= ADDR_W'(NUM_IRQ)) |=> (rdata_o == '0));

  p_ns_rd_lsb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && restrict_acc) |=> ((rdata_o & {LANES{8'h01}}) == '0));

  p_byte_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !word_i) |=> (rdata_o[DATA_W-1:PRIO_W] == '0));
endmodule

// File: tb/prio_bank_ram_bench.sv
module prio_bank_ram_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0, word = 1'b0, sec = 1'b0, dis = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [N-1:0] grp = '0;
  logic         rvalid;
  logic [31:0]  rdata;
  logic [N*8-1:0] prio;

  int model [N];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_bank_ram u_prio_bank_ram (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .secure_i(sec), .sec_dis_i(dis),
    .group_i(grp), .rvalid_o(rvalid), .rdata_o(rdata), .prio_o(prio)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int m_rd(int i, bit s, bit d);
    if (s || d) return model[i];
    if (!grp[i]) return 0;
    return (model[i] << 1) & 255;
  endfunction

  // per-clock comparison of the whole array against the model (R10 / R2 visibility)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++)
        chk($sformatf("R10 prio_o[%0d]", i), 32'(prio[i*8 +: 8]), 32'(model[i]));
    end
  end

  task automatic access(bit w, bit wd, int a, logic [31:0] d, bit s, bit ds, string tag);
    logic [31:0] exp = '0;
    bit hit = (a < N) && (!wd || (a % 4 == 0));
    int nl = wd ? 4 : 1;
    if (!w && hit)
      for (int k = 0; k < nl; k++) exp[k*8 +: 8] = 8'(m_rd(a + k, s, ds));
    @(negedge clk);
    req = 1'b1; we = w; word = wd; addr = 8'(a); wdata = d; sec = s; dis = ds;
    @(posedge clk);
    if (w && hit) begin
      for (int k = 0; k < nl; k++) begin
        int v = int'(d[k*8 +: 8]);
        if (s || ds) model[a+k] = v;
        else if (grp[a+k]) model[a+k] = 128 | (v >> 1);
      end
    end
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R10 rvalid"}, 32'(rvalid), 32'(!w));
    if (!w) chk({tag, " rdata"}, rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rvalid at reset", 32'(rvalid), 0);
    chk("R1 rdata at reset", rdata, 0);
    chk("R1 prio_o at reset", 32'(prio != '0), 0);
    @(negedge clk); rst_n = 1'b1;

    access(0, 1, 28, 0, 1, 0, "R1 reset read");
    // secure pass-through and lane order
    access(1, 1, 0, 32'h4433_2211, 1, 0, "R2 R7 secure word write");
    access(0, 1, 0, 0, 1, 0, "R7 word read lanes");
    access(0, 0, 2, 0, 1, 0, "R7 byte read");
    access(1, 0, 31, 32'hFFFF_FF5A, 1, 0, "R7 byte write top entry");
    access(0, 1, 28, 0, 1, 0, "R7 word read top");
    // security disabled: non-secure passes through
    access(1, 0, 5, 32'h0000_00A5, 0, 1, "R2 disabled ns write");
    access(0, 0, 5, 0, 0, 1, "R2 disabled ns read");
    // restricted views
    grp = 32'h0000_00F0;
    access(1, 1, 4, 32'hC3C3_C3C3, 1, 0, "R2 secure seed");
    access(0, 0, 1, 0, 0, 0, "R3 ns read group0");
    access(1, 0, 1, 32'h0000_0077, 0, 0, "R4 ns write group0");
    access(0, 0, 1, 0, 1, 0, "R4 secure check group0");
    access(1, 0, 6, 32'h0000_003C, 0, 0, "R6 ns write group1");
    access(0, 0, 6, 0, 1, 0, "R6 secure view 0x9E");
    access(0, 0, 6, 0, 0, 0, "R5 ns read group1");
    access(0, 1, 4, 0, 0, 0, "R5 ns word read");
    access(0, 1, 0, 0, 0, 0, "R3 ns word group0");
    // mixed groups in one word
    grp = 32'h0000_0050;
    access(1, 1, 4, 32'h1122_FE01, 0, 0, "R8 ns mixed word write");
    access(0, 1, 4, 0, 1, 0, "R8 secure mixed check");
    access(0, 1, 4, 0, 0, 0, "R8 ns mixed read");
    // errors
    access(0, 0, 32, 0, 1, 0, "R9 read offset 32");
    access(1, 0, 32, 32'h0000_00EE, 1, 0, "R9 write offset 32");
    access(0, 1, 2, 0, 1, 0, "R9 misaligned word read");
    access(1, 1, 2, 32'hDEAD_BEEF, 1, 0, "R9 misaligned word write");
    access(0, 1, 0, 0, 1, 0, "R9 check after misaligned");
    access(1, 1, 252, 32'h1234_5678, 1, 0, "R9 write offset 252");
    access(0, 0, 255, 0, 1, 0, "R9 read offset 255");
    // idle cycle: rvalid low
    @(negedge clk);
    chk("R10 idle rvalid", 32'(rvalid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule